// File: doc/BRIEF.md
# Controller Progress Trace Logger

This block turns progress events from a storage-card controller into short, human-readable ASCII lines and shifts them out on a single serial transmit wire. One producer presents an event on a valid/ready handshake. The event carries a 2-bit kind, an 8-bit command number and a response word. The logger accepts the event only when it is idle. It then formats one line: a prefix letter, either two decimal digits, a verdict letter or a hexadecimal dump, and a CR LF terminator. Ready stays low until the last stop bit of that line has left the wire. Because there is a single producer and acceptance happens only in idle, lines never interleave and no arbitration is needed.

Bit timing comes from a clock-enable counter on the system clock. The counter divides `CLK_HZ` by `BAUD`, which defaults to 230400 bits per second. Each character is an 8N1 frame. After every reset the logger prints a lone dash line, so a reset is visible in the trace.

Formatter states are `F_DASH`, `F_IDLE`, `F_LEAD`, `F_TENS`, `F_ONES`, `F_HEX`, `F_CR`, `F_LF` and `F_DRAIN`. The character states are `F_DASH`, `F_LEAD`, `F_TENS`, `F_ONES`, `F_HEX`, `F_CR` and `F_LF`. Each of them advances when the transmitter is free and takes its character.

- `F_DASH` goes to `F_CR`.
- `F_IDLE` goes to `F_LEAD` when an event is accepted.
- `F_LEAD` goes to `F_TENS` for a command or application command, to `F_CR` for a status event, and to `F_HEX` for an unexpected response.
- `F_TENS` goes to `F_ONES`, and `F_ONES` goes to `F_CR`.
- `F_HEX` loops until the last nibble, then goes to `F_CR`.
- `F_CR` goes to `F_LF`, and `F_LF` goes to `F_DRAIN`.
- `F_DRAIN` returns to `F_IDLE` once the transmitter is idle again.

Transmitter states are `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`:
- `TX_IDLE` goes to `TX_START` on a load.
- `TX_START` goes to `TX_DATA` on a bit tick.
- `TX_DATA` goes to `TX_STOP` on the tick that ends bit 7.
- `TX_STOP` goes to `TX_IDLE` on a bit tick.

Top module: `trace_logger`

## Requirements
- R1: While reset is held, `uart_txd` is 1 and `ev_ready` is 0. After release, the line "-" followed by CR (0x0D) and LF (0x0A) is sent before `ev_ready` first rises.
- R2: Each character is one frame: a start bit of 0, eight data bits least significant first, and a stop bit of 1. Every bit lasts CLK_HZ/BAUD clock cycles.
- R3: Kind code 0 (command) produces "C", then `ev_num` as two decimal digits, then CR LF. For example, 8 gives "C08".
- R4: Kind code 1 (application command) produces "A", then two decimal digits of `ev_num`, then CR LF.
- R5: Kind code 2 (status) produces "S" when `ev_num` bit 0 is 0 and "E" when it is 1, then CR LF.
- R6: Kind code 3 (unexpected response) produces "X", then all 2*RESP_BYTES nibbles of `ev_resp`, most significant first, as uppercase 0-9/A-F, then CR LF.
- R7: `ev_ready` is 1 only when the logger is idle. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both 1. `ev_ready` is 0 from the next cycle until the stop bit of that line's LF has been fully sent.
- R8: While `ev_ready` is 0, `ev_valid`, `ev_kind`, `ev_num` and `ev_resp` have no effect. The line being sent is unchanged, and no further line appears.
- R9: A command number of 100 or more is printed as its value modulo 100. For example, 255 gives "55".
- R10: With `ev_valid` held at 1 across consecutive events, each event is taken on the first cycle `ev_ready` is 1. Every line appears once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Producer presents an event |
| ev_ready | output | 1 | Logger idle and able to take an event |
| ev_kind | input | 2 | 0 command, 1 application command, 2 status, 3 unexpected response |
| ev_num | input | 8 | Command number, or status verdict in bit 0 |
| ev_resp | input | 8*RESP_BYTES | Response word dumped in hexadecimal |
| uart_txd | output | 1 | Serial transmit line, idle high |

## Verification
The two things that can meet in one cycle are the end of a line's final stop bit, which lets ready rise, and a producer that already holds valid with the next event. The bench provokes this by keeping `ev_valid` high through streams of back-to-back directed and random events. It judges the result by decoding the serial wire with an independent receiver and comparing every line, in order, with text computed from the requirements. A second collision, field changes and valid pulses arriving while a line is still shifting, is driven on purpose. It is judged by the decoded line and by the silence after it.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;

    typedef enum logic [1:0] {
        EV_CMD    = 2'd0,
        EV_ACMD   = 2'd1,
        EV_STATUS = 2'd2,
        EV_UNEXP  = 2'd3
    } ev_kind_e;

    typedef enum logic [3:0] {
        F_DASH,
        F_IDLE,
        F_LEAD,
        F_TENS,
        F_ONES,
        F_HEX,
        F_CR,
        F_LF,
        F_DRAIN
    } fmt_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    localparam logic [7:0] CH_DASH = 8'h2D;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_C    = 8'h43;
    localparam logic [7:0] CH_A    = 8'h41;
    localparam logic [7:0] CH_S    = 8'h53;
    localparam logic [7:0] CH_E    = 8'h45;
    localparam logic [7:0] CH_X    = 8'h58;
    localparam logic [7:0] CH_ZERO = 8'h30;

    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10)
            return CH_ZERO + {4'h0, nib};
        else
            return 8'h37 + {4'h0, nib};
    endfunction

    function automatic logic [7:0] dec_char(input logic [3:0] digit);
        return CH_ZERO + {4'h0, digit};
    endfunction

endpackage

// File: rtl/trace_baud_gen.sv
module trace_baud_gen #(
    parameter int BIT_CYCLES = 434
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/trace_uart_tx.sv
module trace_uart_tx
    import trace_log_pkg::*;
#(
    parameter int BIT_CYCLES = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       free,
    output logic       txd
);
    tx_state_e  state_q, state_d;
    logic [7:0] shreg_q;
    logic [2:0] bit_q;
    logic       tick;

    trace_baud_gen #(.BIT_CYCLES(BIT_CYCLES)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != TX_IDLE),
        .tick  (tick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (tick) state_d = TX_DATA;
            TX_DATA:  if (tick && bit_q == 3'd7) state_d = TX_STOP;
            TX_STOP:  if (tick) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= 8'hFF;
            bit_q   <= 3'd0;
        end else if (state_q == TX_IDLE && load) begin
            shreg_q <= data;
            bit_q   <= 3'd0;
        end else if (state_q == TX_DATA && tick) begin
            shreg_q <= {1'b1, shreg_q[7:1]};
            bit_q   <= bit_q + 3'd1;
        end
    end

    always_comb begin
        free = (state_q == TX_IDLE);
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg_q[0];
            default:  txd = 1'b1;
        endcase
    end

    AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(free) |-> $past(load)); // R2
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(free) |-> !txd); // R2

endmodule

// File: rtl/trace_formatter.sv
module trace_formatter
    import trace_log_pkg::*;
#(
    parameter int RESP_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_valid,
    input  logic [1:0]              ev_kind,
    input  logic [7:0]              ev_num,
    input  logic [8*RESP_BYTES-1:0] ev_resp,
    input  logic                    tx_free,
    output logic                    ev_ready,
    output logic                    ch_valid,
    output logic [7:0]              ch_data
);
    localparam int RESP_W = 8 * RESP_BYTES;
    localparam int NIBS   = 2 * RESP_BYTES;
    localparam int NIB_W  = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [NIB_W-1:0] NIB_LAST = NIB_W'(NIBS - 1);

    fmt_state_e        state_q, state_d;
    ev_kind_e          kind_q;
    logic [3:0]        tens_q, ones_q;
    logic              err_q;
    logic [RESP_W-1:0] resp_q;
    logic [NIB_W-1:0]  nib_q;

    logic [7:0] num_mod;
    logic [3:0] tens_d, ones_d;
    logic       take;

    always_comb begin
        num_mod = ev_num % 8'd100;
        tens_d  = 4'(num_mod / 8'd10);
        ones_d  = 4'(num_mod % 8'd10);
    end

    assign take = (state_q == F_IDLE) && ev_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_DASH:  if (tx_free) state_d = F_CR;
            F_IDLE:  if (ev_valid) state_d = F_LEAD;
            F_LEAD: begin
                if (tx_free) begin
                    unique case (kind_q)
                        EV_CMD, EV_ACMD: state_d = F_TENS;
                        EV_STATUS:       state_d = F_CR;
                        EV_UNEXP:        state_d = F_HEX;
                        default:         state_d = F_CR;
                    endcase
                end
            end
            F_TENS:  if (tx_free) state_d = F_ONES;
            F_ONES:  if (tx_free) state_d = F_CR;
            F_HEX:   if (tx_free && nib_q == NIB_LAST) state_d = F_CR;
            F_CR:    if (tx_free) state_d = F_LF;
            F_LF:    if (tx_free) state_d = F_DRAIN;
            F_DRAIN: if (tx_free) state_d = F_IDLE;
            default: state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= F_DASH;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= EV_CMD;
            tens_q <= 4'd0;
            ones_q <= 4'd0;
            err_q  <= 1'b0;
            resp_q <= '0;
            nib_q  <= '0;
        end else if (take) begin
            kind_q <= ev_kind_e'(ev_kind);
            tens_q <= tens_d;
            ones_q <= ones_d;
            err_q  <= ev_num[0];
            resp_q <= ev_resp;
            nib_q  <= '0;
        end else if (state_q == F_HEX && tx_free) begin
            resp_q <= resp_q << 4;
            nib_q  <= nib_q + NIB_W'(1);
        end
    end

    always_comb begin
        ev_ready = (state_q == F_IDLE);
        ch_valid = 1'b1;
        ch_data  = CH_CR;
        unique case (state_q)
            F_DASH: ch_data = CH_DASH;
            F_LEAD: begin
                unique case (kind_q)
                    EV_CMD:    ch_data = CH_C;
                    EV_ACMD:   ch_data = CH_A;
                    EV_STATUS: ch_data = err_q ? CH_E : CH_S;
                    EV_UNEXP:  ch_data = CH_X;
                    default:   ch_data = CH_X;
                endcase
            end
            F_TENS: ch_data = dec_char(tens_q);
            F_ONES: ch_data = dec_char(ones_q);
            F_HEX:  ch_data = hex_char(resp_q[RESP_W-1 -: 4]);
            F_CR:   ch_data = CH_CR;
            F_LF:   ch_data = CH_LF;
            default: ch_valid = 1'b0;
        endcase
    end

    AST_READY_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> tx_free); // R7
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready); // R7
    AST_CHAR_ALPHABET: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_data == CH_CR || ch_data == CH_LF || ch_data == CH_DASH ||
                      (ch_data >= 8'h30 && ch_data <= 8'h39) ||
                      (ch_data >= 8'h41 && ch_data <= 8'h5A))); // R6

endmodule

// File: rtl/trace_logger.sv
module trace_logger
    import trace_log_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 230_400,
    parameter int RESP_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_valid,
    output logic                    ev_ready,
    input  logic [1:0]              ev_kind,
    input  logic [7:0]              ev_num,
    input  logic [8*RESP_BYTES-1:0] ev_resp,
    output logic                    uart_txd
);
    localparam int BIT_CYCLES = CLK_HZ / BAUD;

    logic       tx_free;
    logic       ch_valid;
    logic [7:0] ch_data;

    trace_formatter #(.RESP_BYTES(RESP_BYTES)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_num   (ev_num),
        .ev_resp  (ev_resp),
        .tx_free  (tx_free),
        .ev_ready (ev_ready),
        .ch_valid (ch_valid),
        .ch_data  (ch_data)
    );

    trace_uart_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ch_valid && tx_free),
        .data  (ch_data),
        .free  (tx_free),
        .txd   (uart_txd)
    );

endmodule

// File: tb/tb_trace_logger.sv
module tb_trace_logger;

    localparam int CLK_HZ = 2_304_000;
    localparam int BAUD   = 230_400;
    localparam int N      = CLK_HZ / BAUD;
    localparam int RB     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [1:0]    ev_kind = 2'd0;
    logic [7:0]    ev_num = 8'd0;
    logic [8*RB-1:0] ev_resp = '0;
    logic          uart_txd;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] rx_q[$];
    logic rdy_at_stop = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    trace_logger #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .RESP_BYTES(RB)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_num(ev_num), .ev_resp(ev_resp), .uart_txd(uart_txd)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // independent serial receiver, samples mid-bit on falling clock edges
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && uart_txd == 1'b0) begin
                logic [7:0] b;
                repeat (N/2) @(negedge clk);
                if (uart_txd != 1'b0)
                    check(0, "R2", "start=1", "start=0");
                for (int i = 0; i < 8; i++) begin
                    repeat (N) @(negedge clk);
                    b[i] = uart_txd;
                end
                repeat (N) @(negedge clk);
                if (uart_txd != 1'b1)
                    check(0, "R2", "stop=0", "stop=1");
                rdy_at_stop = ev_ready;
                rx_q.push_back(b);
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        check(0, "WATCHDOG", "timeout", "completion");
        finish_run();
    end

    function automatic string hexstr(input logic [8*RB-1:0] r);
        string s = "";
        for (int i = 2*RB-1; i >= 0; i--) begin
            logic [3:0] nb = r[4*i +: 4];
            s = $sformatf("%s%c", s, (nb < 10) ? (8'h30 + nb) : (8'h37 + nb));
        end
        return s;
    endfunction

    function automatic string exp_line(input logic [1:0] k, input logic [7:0] n,
                                       input logic [8*RB-1:0] r);
        int m = n % 100;
        case (k)
            2'd0: return $sformatf("C%0d%0d", m / 10, m % 10);
            2'd1: return $sformatf("A%0d%0d", m / 10, m % 10);
            2'd2: return n[0] ? "E" : "S";
            default: return {"X", hexstr(r)};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] k, input logic [7:0] n);
        if (n >= 8'd100 && k < 2'd2) return "R9";
        case (k)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic pop_byte(output logic [7:0] b);
        while (rx_q.size() == 0) @(negedge clk);
        b = rx_q.pop_front();
    endtask

    task automatic get_line(output string s);
        logic [7:0] b;
        s = "";
        forever begin
            pop_byte(b);
            if (b == 8'h0D) begin
                pop_byte(b);
                check(b == 8'h0A, "R3", $sformatf("%02h", b), "0a");
                break;
            end
            s = $sformatf("%s%c", s, b);
        end
    endtask

    task automatic present(input logic [1:0] k, input logic [7:0] n, input logic [8*RB-1:0] r);
        logic rdy;
        @(negedge clk);
        ev_kind = k; ev_num = n; ev_resp = r; ev_valid = 1'b1;
        forever begin
            rdy = ev_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
    endtask

    task automatic one_event(input logic [1:0] k, input logic [7:0] n, input logic [8*RB-1:0] r);
        string got, exp;
        present(k, n, r);
        @(negedge clk);
        ev_valid = 1'b0;
        get_line(got);
        exp = exp_line(k, n, r);
        check(got == exp, req_of(k, n), got, exp);
    endtask

    logic [1:0]      s_k[48];
    logic [7:0]      s_n[48];
    logic [8*RB-1:0] s_r[48];
    bit              s_hold[48];

    task automatic run_stream(input int cnt, input string tag);
        fork
            begin
                for (int i = 0; i < cnt; i++) begin
                    present(s_k[i], s_n[i], s_r[i]);
                    if (!s_hold[i]) begin
                        @(negedge clk);
                        ev_valid = 1'b0;
                        repeat ($urandom_range(0, 3*N)) @(negedge clk);
                    end
                end
                @(negedge clk);
                ev_valid = 1'b0;
            end
            begin
                for (int i = 0; i < cnt; i++) begin
                    string got, exp;
                    get_line(got);
                    exp = exp_line(s_k[i], s_n[i], s_r[i]);
                    check(got == exp, tag, got, exp);
                    check(rdy_at_stop == 1'b0, "R7", "ready=1 at LF stop", "ready=0");
                end
            end
        join
    endtask

    initial begin
        string got;
        int cyc;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        check(uart_txd == 1'b1, "R1", $sformatf("%b", uart_txd), "1");
        check(ev_ready == 1'b0, "R1", $sformatf("%b", ev_ready), "0");
        rst_n = 1'b1;

        // R2: start bit width of the dash character
        while (uart_txd != 1'b0) @(negedge clk);
        cyc = 0;
        while (uart_txd == 1'b0) begin cyc++; @(negedge clk); end
        check(cyc == N, "R2", $sformatf("%0d", cyc), $sformatf("%0d", N));

        get_line(got);
        check(got == "-", "R1", got, "-");
        check(rdy_at_stop == 1'b0, "R7", "ready=1", "ready=0");
        cyc = 0;
        while (!ev_ready && cyc < 4*N) begin cyc++; @(negedge clk); end
        check(cyc >= 1 && cyc <= N, "R7", $sformatf("%0d cycles", cyc), "1..N cycles");

        // directed lines
        one_event(2'd0, 8'd0,   '0);
        one_event(2'd0, 8'd8,   '0);
        one_event(2'd0, 8'd55,  '0);
        one_event(2'd1, 8'd41,  '0);
        one_event(2'd1, 8'd6,   '0);
        one_event(2'd2, 8'd0,   '0);
        one_event(2'd2, 8'd1,   '0);
        one_event(2'd2, 8'd254, '0);
        one_event(2'd3, 8'd0,   32'hDEADBEEF);
        one_event(2'd3, 8'd0,   32'h0123ABCD);
        one_event(2'd0, 8'd255, '0);
        one_event(2'd1, 8'd100, '0);
        one_event(2'd0, 8'd99,  '0);

        // R8: noise on the inputs while a line is shifting
        present(2'd1, 8'd13, '0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ev_valid = 1'($urandom);
            ev_kind  = 2'($urandom);
            ev_num   = 8'($urandom);
            ev_resp  = $urandom;
        end
        @(negedge clk);
        ev_valid = 1'b0;
        get_line(got);
        check(got == "A13", "R8", got, "A13");
        while (!ev_ready) @(negedge clk);
        repeat (15*N) @(negedge clk);
        check(rx_q.size() == 0 && uart_txd == 1'b1, "R8",
              $sformatf("%0d extra bytes", rx_q.size()), "0 extra bytes");

        // R10: directed back-to-back with valid held high
        s_k[0] = 2'd0; s_n[0] = 8'd2;  s_r[0] = '0;
        s_k[1] = 2'd0; s_n[1] = 8'd3;  s_r[1] = '0;
        s_k[2] = 2'd3; s_n[2] = 8'd0;  s_r[2] = 32'hF00DCAFE;
        s_k[3] = 2'd2; s_n[3] = 8'd0;  s_r[3] = '0;
        for (int i = 0; i < 4; i++) s_hold[i] = 1'b1;
        run_stream(4, "R10");

        // random stream, mixed holding and gaps
        for (int i = 0; i < 40; i++) begin
            s_k[i]    = 2'($urandom);
            s_n[i]    = 8'($urandom);
            s_r[i]    = $urandom;
            s_hold[i] = 1'($urandom);
        end
        run_stream(40, "R10");

        done = 1'b1;
        finish_run();
    end

endmodule